// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a parameterised universal shift register, eight bits wide by default. A single tri-state parallel port carries data both ways: it loads the register and it shows the register's contents. Each end of the register has a serial input. Two mode-select pins pick one of four operations, applied on the rising clock edge: keep the contents, shift toward the most significant bit, shift toward the least significant bit, or load from the port.

The port is bidirectional, so ownership of the bus follows fixed rules. The block drives the register value onto the port only when both active-low output enables are low and the block is not in load mode. Selecting load always releases the port, whatever the enables are doing, so an external agent can place data on it for capture. An active-low asynchronous reset clears the register and has priority over everything else.

Both end bits are also brought out as serial outputs that are always driven. Several blocks can therefore be chained into a longer shifter, with one block's end tap feeding the next block's serial input. The mode and data interfaces are plain level-sampled pins with no handshake, because every operation completes in one clock edge and nothing is queued. No back-pressure exists.

Top module: `usr_shift_reg`

## Requirements
- R1: While `rst_n` is low, every register bit is 0. This takes effect immediately, without waiting for a clock edge, and it overrides the mode, serial and port inputs.
- R2: With `mode` = 2'b00, a rising edge leaves all register bits unchanged.
- R3: With `mode` = 2'b01, a rising edge moves bit i to bit i+1, and `ser_lo` enters bit 0.
- R4: With `mode` = 2'b10, a rising edge moves bit i+1 to bit i, and `ser_hi` enters bit WIDTH-1.
- R5: With `mode` = 2'b11, a rising edge copies the value present on `data_io` into the register.
- R6: While `mode` = 2'b11, the block does not drive `data_io`, whatever the levels of `oe_a_n` and `oe_b_n`.
- R7: The block drives `data_io` with the register value only when `oe_a_n` = 0, `oe_b_n` = 0 and `mode` is not 2'b11. Otherwise the port is released.
- R8: `tap_lo` always equals register bit 0 and `tap_hi` always equals bit WIDTH-1, whatever the mode and enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all operations act on the rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | Operation select: 00 hold, 01 shift up, 10 shift down, 11 parallel load |
| oe_a_n | input | 1 | First port output enable, active low |
| oe_b_n | input | 1 | Second port output enable, active low |
| ser_lo | input | 1 | Serial input that enters bit 0 on an upward shift |
| ser_hi | input | 1 | Serial input that enters the top bit on a downward shift |
| data_io | inout | WIDTH | Shared parallel port: load source, or register readout |
| tap_lo | output | 1 | Register bit 0, always driven |
| tap_hi | output | 1 | Register top bit, always driven |

## Verification
A wrong bit in the register shows on the end taps within the same cycle if it sits at either end. Otherwise it reaches a tap only after enough shifts to walk it there, or after the next readout cycle with both enables low. A fault in the port ownership logic shows as a corrupted capture during a load, or as a wrong value read from a bus the block should have released. The bench therefore follows every load and every disabled-enable phase with a readout. A reset fault shows on both taps before the next clock edge.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DN   = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
  import usr_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       oe_a_n,
  input  logic       oe_b_n,
  output usr_mode_e  op,
  output logic       drive_en
);
  // Load releases the port regardless of the enables.
  always_comb begin
    op       = usr_mode_e'(mode);
    drive_en = (op != MODE_LOAD) && !oe_a_n && !oe_b_n;
  end
endmodule

// File: rtl/usr_bit_cell.sv
module usr_bit_cell
  import usr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  usr_mode_e op,
  input  logic      from_below,
  input  logic      from_above,
  input  logic      par_bit,
  output logic      q
);
  logic nxt;

  always_comb begin
    unique case (op)
      MODE_UP:   nxt = from_below;
      MODE_DN:   nxt = from_above;
      MODE_LOAD: nxt = par_bit;
      default:   nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt;
  end
endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic             ser_lo,
  input  logic             ser_hi,
  inout  wire  [WIDTH-1:0] data_io,
  output logic             tap_lo,
  output logic             tap_hi
);
  localparam int MSB = WIDTH - 1;

  usr_mode_e        op;
  logic             drive_en;
  logic [WIDTH-1:0] q;
  logic [WIDTH:0]   up_chain;   // up_chain[i] feeds bit i on an upward shift
  logic [WIDTH:0]   dn_chain;   // dn_chain[i+1] feeds bit i on a downward shift
  logic [WIDTH-1:0] par_in;

  usr_mode_decode u_dec (
    .mode     (mode),
    .oe_a_n   (oe_a_n),
    .oe_b_n   (oe_b_n),
    .op       (op),
    .drive_en (drive_en)
  );

  assign up_chain = {q, ser_lo};
  assign dn_chain = {ser_hi, q};
  assign par_in   = data_io;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    usr_bit_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .op         (op),
      .from_below (up_chain[i]),
      .from_above (dn_chain[i+1]),
      .par_bit    (par_in[i]),
      .q          (q[i])
    );
  end

  assign data_io = drive_en ? q : {WIDTH{1'bz}};
  assign tap_lo  = q[0];
  assign tap_hi  = q[MSB];
endmodule

// File: rtl/usr_shift_reg_chk.sv
module usr_shift_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             oe_a_n,
  input logic             oe_b_n,
  input logic             ser_lo,
  input logic             ser_hi,
  input logic [WIDTH-1:0] port_val,
  input logic [WIDTH-1:0] q_state,
  input logic             drive_en
);
  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |-> q_state == '0);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |=> $stable(q_state));

  p_shift_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |=> q_state == {$past(q_state[WIDTH-2:0]), $past(ser_lo)});

  p_shift_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |=> q_state == {$past(ser_hi), $past(q_state[WIDTH-1:1])});

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |=> q_state == $past(port_val));

  p_load_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |-> !drive_en);

  p_drive_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> (!oe_a_n && !oe_b_n));
endmodule

bind usr_shift_reg usr_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .oe_a_n   (oe_a_n),
  .oe_b_n   (oe_b_n),
  .ser_lo   (ser_lo),
  .ser_hi   (ser_hi),
  .port_val (data_io),
  .q_state  (q),
  .drive_en (drive_en)
);

// File: tb/tb_usr_shift_reg.sv
`timescale 1ns/1ps
module tb_usr_shift_reg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         oe_a_n = 1'b1, oe_b_n = 1'b1;
  logic         ser_lo = 1'b0, ser_hi = 1'b0;
  logic         ext_en = 1'b0;
  logic [W-1:0] ext_val = '0;
  wire  [W-1:0] bus;
  logic         tap_lo, tap_hi;
  logic [W-1:0] exp_q = '0;
  int           checks = 0, errors = 0;
  bit           done = 0;

  assign bus = ext_en ? ext_val : {W{1'bz}};

  usr_shift_reg #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .ser_lo(ser_lo), .ser_hi(ser_hi), .data_io(bus),
    .tap_lo(tap_lo), .tap_hi(tap_hi)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // The external driver may only be active while the block is released.
  always @(negedge clk) begin
    if (ext_en && !(mode == 2'b11 || oe_a_n || oe_b_n)) begin
      checks++; errors++;
      $display("FAIL R7 actual=both_drivers expected=one_driver");
    end
  end

  // One rising edge with the given inputs; the model follows R2..R5.
  task automatic step(input logic [1:0] m, input logic sl, input logic sh,
                      input logic [W-1:0] pv);
    @(negedge clk);
    mode = m; ser_lo = sl; ser_hi = sh;
    oe_a_n = 1'b1; oe_b_n = 1'b1;
    ext_en = (m == 2'b11); ext_val = pv;
    @(posedge clk);
    case (m)
      2'b01: exp_q = {exp_q[W-2:0], sl};
      2'b10: exp_q = {sh, exp_q[W-1:1]};
      2'b11: exp_q = pv;
      default: ;
    endcase
    #1;
    chk("R8 tap_lo", {{(W-1){1'b0}}, tap_lo}, {{(W-1){1'b0}}, exp_q[0]});
    chk("R8 tap_hi", {{(W-1){1'b0}}, tap_hi}, {{(W-1){1'b0}}, exp_q[W-1]});
  endtask

  // Readout in hold mode with both enables low (R7).
  task automatic readout(input string req);
    @(negedge clk);
    ext_en = 1'b0; mode = 2'b00; oe_a_n = 1'b0; oe_b_n = 1'b0;
    #1 chk(req, bus, exp_q);
    @(negedge clk);
    oe_a_n = 1'b1; oe_b_n = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    exp_q = '0;
    readout("R1 reset state");
  endtask

  task automatic t_load();
    step(2'b11, 1'b0, 1'b0, 8'hA5);
    readout("R5 load A5");
    step(2'b11, 1'b1, 1'b1, 8'h3C);
    readout("R5 load 3C");
  endtask

  task automatic t_load_with_enables();
    // Enables low while loading: the port must still be released (R6).
    @(negedge clk);
    mode = 2'b11; oe_a_n = 1'b0; oe_b_n = 1'b0; ext_en = 1'b1; ext_val = 8'h96;
    @(posedge clk); exp_q = 8'h96;
    #1 chk("R6 bus owned by external during load", bus, 8'h96);
    @(negedge clk); ext_en = 1'b0; mode = 2'b00; oe_a_n = 1'b1; oe_b_n = 1'b1;
    readout("R6 capture with enables low");
  endtask

  task automatic t_enable_gate();
    // One enable high: block released, external value seen unchanged (R7).
    @(negedge clk);
    mode = 2'b00; oe_a_n = 1'b1; oe_b_n = 1'b0; ext_en = 1'b1; ext_val = 8'h0F;
    #1 chk("R7 released oe_a_n high", bus, 8'h0F);
    @(negedge clk);
    oe_a_n = 1'b0; oe_b_n = 1'b1; ext_val = 8'hF0;
    #1 chk("R7 released oe_b_n high", bus, 8'hF0);
    @(negedge clk); ext_en = 1'b0; oe_b_n = 1'b1;
    readout("R7 readout after released phase");
  endtask

  task automatic t_shift_up();
    step(2'b11, 1'b0, 1'b0, 8'h81);
    step(2'b01, 1'b1, 1'b0, '0);
    step(2'b01, 1'b0, 1'b1, '0);
    step(2'b01, 1'b1, 1'b0, '0);
    readout("R3 shift up");
  endtask

  task automatic t_shift_down();
    step(2'b11, 1'b0, 1'b0, 8'h81);
    step(2'b10, 1'b0, 1'b1, '0);
    step(2'b10, 1'b1, 1'b0, '0);
    step(2'b10, 1'b0, 1'b1, '0);
    readout("R4 shift down");
  endtask

  task automatic t_walk_through();
    step(2'b11, 1'b0, 1'b0, 8'h00);
    for (int i = 0; i < W; i++) step(2'b01, 1'b1, 1'b0, '0);
    readout("R3 fill with ones");
    for (int i = 0; i < W; i++) step(2'b10, 1'b1, 1'b0, '0);
    readout("R4 drain with zeros");
  endtask

  task automatic t_hold();
    step(2'b11, 1'b0, 1'b0, 8'h5A);
    step(2'b00, 1'b1, 1'b1, '0);
    step(2'b00, 1'b0, 1'b1, '0);
    readout("R2 hold ignores serial inputs");
  endtask

  task automatic t_async_reset();
    step(2'b11, 1'b0, 1'b0, 8'hFF);
    @(negedge clk); mode = 2'b11; ext_en = 1'b1; ext_val = 8'hFF;
    #1 rst_n = 1'b0; exp_q = '0;
    #0.5;
    chk("R1 async clear before edge", {6'b0, tap_hi, tap_lo}, 8'h00);
    @(posedge clk); #1;
    chk("R1 overrides load", {6'b0, tap_hi, tap_lo}, 8'h00);
    @(negedge clk); ext_en = 1'b0; mode = 2'b00; rst_n = 1'b1;
    readout("R1 register clear after reset");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_load();
        t_load_with_enables();
        t_enable_gate();
        t_shift_up();
        t_shift_down();
        t_walk_through();
        t_hold();
        t_async_reset();
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule